// File: doc/BRIEF.md
# Scheduled Static Crossbar Switch

This block is a five-port crossbar whose connections for each step come from a small program held in a local instruction memory, not from anything carried in the data. The ports face north, south, east, west and the local processor. Each port has an input with a small FIFO and an output with a one-word holding register, and both sides use valid/ready flow control. Words have no header, so every bit of a word is payload and passes through unchanged.

Each instruction gives one source selector per output, plus the address of the next instruction. An instruction commits as a single unit. It commits only when every input it reads holds a word and every output it writes can take one. If either condition fails, the whole instruction waits and the program counter stays where it is. One input word may feed several outputs in the same step, and that word is consumed once. Software loads the program through a write port that works only while the switch is held in reset.

Top module: `sched_xbar`

## Requirements
- R1: While reset is asserted and after it is released, no output is valid, every input FIFO is empty (all `in_ready` high), and the program counter is 0.
- R2: An input word is accepted on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` goes low once that port's FIFO holds FIFO_DEPTH (2) words. A word offered while `in_ready` is low is dropped.
- R3: Instruction bits [3o+2:3o] select the source of output o. Ports are indexed N=0, S=1, E=2, W=3, P=4, and selector codes 0 to 4 name those inputs. Codes 5, 6 and 7 leave the output idle. A word accepted at edge k reaches its output, valid, after edge k+1 when its instruction is current and not stalled.
- R4: When several outputs select the same input, all of them receive the same word in the same commit, and that input gives up exactly one word.
- R5: An instruction commits only if every selected input FIFO is non-empty and every used output has space. Otherwise no output is loaded, no input word is consumed and the program counter holds.
- R6: An output register that is valid while its `out_ready` is low keeps its word stable. The output has space when it is empty or is being drained in the same cycle, so a drain and a new load can happen on one edge.
- R7: On a commit the program counter takes the next-address field, instruction bits [18:15]. An instruction with every output idle commits without needing any data.
- R8: When `ld_en` is high during reset, `ld_data` is written to instruction address `ld_addr`. When reset is not asserted, `ld_en` has no effect.
- R9: Words travel at their full DW (32) bits with no header, and all bits reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; program loading is allowed while low |
| ld_en | input | 1 | Instruction memory write strobe (reset only) |
| ld_addr | input | PC_W (4) | Instruction memory write address |
| ld_data | input | IW (19) | Instruction word: five 3-bit selectors, then 4-bit next address |
| in_data | input | 5 x DW | Input words, one per port N,S,E,W,P |
| in_valid | input | 5 | Input word present, per port |
| in_ready | output | 5 | Input FIFO has room, per port |
| out_data | output | 5 x DW | Output words, one per port |
| out_valid | output | 5 | Output register holds a word, per port |
| out_ready | input | 5 | Downstream takes the output word, per port |

## Verification
Two events can fall on the same edge. One is an output draining while the next instruction loads a new word into it. The other is a partial block, where one destination is full while another destination of the same instruction is free. The first case is provoked by holding an output's ready low across a waiting instruction and then raising it. The check is that the new word appears right after the edge that drains the old one, with no gap. The second case uses a fan-out instruction with only one output blocked. The check is that the free output stays empty, the input FIFO fills until `in_ready` drops, and both outputs then receive the words in order once the block clears.

// File: rtl/sched_xbar_pkg.sv
package sched_xbar_pkg;
    localparam int NPORT = 5;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_N    = 3'd0,
        SRC_S    = 3'd1,
        SRC_E    = 3'd2,
        SRC_W    = 3'd3,
        SRC_P    = 3'd4,
        SRC_IDLE = 3'd7
    } src_sel_e;
endpackage

// File: rtl/sched_xbar_fifo.sv
module sched_xbar_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign push_ready = (st_q.count != CW'(DEPTH));
    assign nonempty   = (st_q.count != '0);
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && nonempty;
    assign head       = mem[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (do_push)
            st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        if (do_pop)
            st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= push_data;
    end
endmodule

// File: rtl/sched_xbar_imem.sv
module sched_xbar_imem #(
    parameter int IW    = 19,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sched_xbar_ctrl.sv
module sched_xbar_ctrl #(
    parameter int NPORT = 5,
    parameter int SEL_W = 3,
    parameter int PC_W  = 4,
    parameter int IW    = 19
) (
    input  logic [IW-1:0]                  instr,
    input  logic [NPORT-1:0]               src_nonempty,
    input  logic [NPORT-1:0]               out_space,
    output logic                           fire,
    output logic [NPORT-1:0]               src_pop,
    output logic [NPORT-1:0]               dst_load,
    output logic [NPORT-1:0][SEL_W-1:0]    sel,
    output logic [PC_W-1:0]                next_pc
);
    logic [NPORT-1:0] dst_used;
    logic [NPORT-1:0] src_used;
    logic src_ok, dst_ok;

    for (genvar o = 0; o < NPORT; o++) begin : g_dec
        assign sel[o]      = instr[o*SEL_W +: SEL_W];
        assign dst_used[o] = (sel[o] < SEL_W'(NPORT));
    end

    always_comb begin
        src_used = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                if (dst_used[o] && (sel[o] == SEL_W'(i))) src_used[i] = 1'b1;
            end
        end
    end

    assign src_ok   = &(~src_used | src_nonempty);
    assign dst_ok   = &(~dst_used | out_space);
    assign fire     = src_ok && dst_ok;
    assign src_pop  = src_used & {NPORT{fire}};
    assign dst_load = dst_used & {NPORT{fire}};
    assign next_pc  = instr[IW-1 -: PC_W];
endmodule

// File: rtl/sched_xbar.sv
module sched_xbar
    import sched_xbar_pkg::*;
#(
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 2,
    parameter int IMEM_DEPTH = 16,
    localparam int PC_W      = $clog2(IMEM_DEPTH),
    localparam int IW        = NPORT * SEL_W + PC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [PC_W-1:0]           ld_addr,
    input  logic [IW-1:0]             ld_data,
    input  logic [NPORT-1:0][DW-1:0]  in_data,
    input  logic [NPORT-1:0]          in_valid,
    output logic [NPORT-1:0]          in_ready,
    output logic [NPORT-1:0][DW-1:0]  out_data,
    output logic [NPORT-1:0]          out_valid,
    input  logic [NPORT-1:0]          out_ready
);
    localparam int NP = NPORT;

    typedef struct packed {
        logic [PC_W-1:0]          pc;
        logic [NP-1:0]            ovalid;
        logic [NP-1:0][DW-1:0]    odata;
    } sw_st_t;

    sw_st_t st_d, st_q;

    logic [NP-1:0][DW-1:0]     head;
    logic [NP-1:0]             nonempty;
    logic [NP-1:0]             src_pop;
    logic [NP-1:0]             dst_load;
    logic [NP-1:0]             out_space;
    logic [NP-1:0][SEL_W-1:0]  sel;
    logic [IW-1:0]             instr;
    logic [PC_W-1:0]           next_pc;
    logic [PC_W-1:0]           pc_cur;
    logic                      fire;

    for (genvar p = 0; p < NP; p++) begin : g_port
        sched_xbar_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[p]),
            .push_data  (in_data[p]),
            .push_ready (in_ready[p]),
            .pop        (src_pop[p]),
            .head       (head[p]),
            .nonempty   (nonempty[p])
        );
        assign out_space[p] = !st_q.ovalid[p] || out_ready[p];
    end

    sched_xbar_imem #(.IW(IW), .DEPTH(IMEM_DEPTH), .AW(PC_W)) u_imem (
        .clk   (clk),
        .we    (ld_en && !rst_n),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_q.pc),
        .rdata (instr)
    );

    sched_xbar_ctrl #(.NPORT(NP), .SEL_W(SEL_W), .PC_W(PC_W), .IW(IW)) u_ctrl (
        .instr        (instr),
        .src_nonempty (nonempty),
        .out_space    (out_space),
        .fire         (fire),
        .src_pop      (src_pop),
        .dst_load     (dst_load),
        .sel          (sel),
        .next_pc      (next_pc)
    );

    always_comb begin
        st_d = st_q;
        if (fire) st_d.pc = next_pc;
        for (int o = 0; o < NP; o++) begin
            if (dst_load[o]) begin
                st_d.ovalid[o] = 1'b1;
                for (int i = 0; i < NP; i++) begin
                    if (sel[o] == SEL_W'(i)) st_d.odata[o] = head[i];
                end
            end else if (out_ready[o]) begin
                st_d.ovalid[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_cur    = st_q.pc;
    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.odata;
endmodule

// File: rtl/sched_xbar_chk.sv
module sched_xbar_chk #(
    parameter int NPORT = 5,
    parameter int DW    = 32,
    parameter int PC_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NPORT-1:0]          out_valid,
    input logic [NPORT-1:0]          out_ready,
    input logic [NPORT-1:0][DW-1:0]  out_data,
    input logic                      fire,
    input logic [PC_W-1:0]           pc,
    input logic [PC_W-1:0]           next_pc
);
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o])))
            else $error("output %0d lost or changed a held word", o);

        p_rise_needs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_valid[o]) |-> $past(fire))
            else $error("output %0d became valid without a commit", o);
    end

    p_stall_holds_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(pc))
        else $error("program counter moved on a stalled step");

    p_commit_next_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pc == $past(next_pc)))
        else $error("program counter did not take the next-address field");
endmodule

bind sched_xbar sched_xbar_chk #(.NPORT(NP), .DW(DW), .PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .fire      (fire),
    .pc        (pc_cur),
    .next_pc   (next_pc)
);

// File: tb/sim_sched_xbar.sv
module sim_sched_xbar;
    localparam int NP = 5;
    localparam int DW = 32;
    localparam int PW = 4;
    localparam int IW = 19;
    localparam int NV = 7;

    // vector: [24:20] inputs pushed, [19:15] outputs expected, [14:0] source per output (3 bits each, output 0 lowest)
    localparam logic [24:0] VEC [NV] = '{
        {5'h09, 5'h14, 3'd0, 3'd7, 3'd3, 3'd7, 3'd7},
        {5'h10, 5'h03, 3'd7, 3'd7, 3'd7, 3'd4, 3'd4},
        {5'h04, 5'h00, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7},
        {5'h02, 5'h0C, 3'd7, 3'd2, 3'd1, 3'd7, 3'd7},
        {5'h0B, 5'h0B, 3'd7, 3'd3, 3'd7, 3'd0, 3'd1},
        {5'h01, 5'h04, 3'd7, 3'd7, 3'd0, 3'd7, 3'd7},
        {5'h01, 5'h04, 3'd7, 3'd7, 3'd0, 3'd7, 3'd7}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   ld_en = 1'b0;
    logic [PW-1:0]          ld_addr = '0;
    logic [IW-1:0]          ld_data = '0;
    logic [NP-1:0][DW-1:0]  in_data = '0;
    logic [NP-1:0]          in_valid = '0;
    logic [NP-1:0]          in_ready;
    logic [NP-1:0][DW-1:0]  out_data;
    logic [NP-1:0]          out_valid;
    logic [NP-1:0]          out_ready = '1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] mq [NP][16];
    int qh [NP];
    int qt [NP];

    sched_xbar u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    always #10 clk = ~clk;

    function automatic logic [IW-1:0] mk(input logic [2:0] n, s, e, w, p, input logic [PW-1:0] nxt);
        return {nxt, p, w, e, s, n};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [PW-1:0] a, input logic [IW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_vec(input logic [24:0] v, input int step, input string req);
        logic [4:0] inm, outm;
        logic [2:0] src;
        bit used [NP];
        inm = v[24:20];
        outm = v[19:15];
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            in_valid[p] = inm[p];
            in_data[p]  = {8'(step), 8'(p), 16'hA5F0} ^ 32'hFFFF_0000;
            if (inm[p]) begin
                mq[p][qt[p] % 16] = in_data[p];
                qt[p]++;
            end
        end
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        chk(out_valid == outm, req, 32'(out_valid), 32'(outm));
        for (int p = 0; p < NP; p++) used[p] = 1'b0;
        for (int o = 0; o < NP; o++) begin
            if (outm[o]) begin
                src = v[o*3 +: 3];
                chk(out_data[o] == mq[src][qh[src] % 16], {req, " R9 data"},
                    out_data[o], mq[src][qh[src] % 16]);
                used[src] = 1'b1;
            end
        end
        for (int p = 0; p < NP; p++) if (used[p]) qh[p]++;
    endtask

    task automatic push1(input int p, input logic [DW-1:0] d);
        @(negedge clk);
        in_valid[p] = 1'b1; in_data[p] = d;
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin qh[p] = 0; qt[p] = 0; end
        // R8: program loaded during reset
        load(4'd0, mk(3'd7, 3'd7, 3'd3, 3'd7, 3'd0, 4'd1));
        load(4'd1, mk(3'd4, 3'd4, 3'd7, 3'd7, 3'd7, 4'd2));
        load(4'd2, mk(3'd7, 3'd7, 3'd1, 3'd2, 3'd7, 4'd3));
        load(4'd3, mk(3'd5, 3'd6, 3'd7, 3'd5, 3'd6, 4'd4));
        load(4'd4, mk(3'd1, 3'd0, 3'd7, 3'd3, 3'd7, 4'd5));
        load(4'd5, mk(3'd7, 3'd7, 3'd0, 3'd7, 3'd7, 4'd5));
        chk(out_valid == '0, "R1 outputs idle in reset", 32'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 outputs idle after reset", 32'(out_valid), 0);
        chk(in_ready == '1, "R1 fifos empty after reset", 32'(in_ready), 32'h1F);

        // R3 R4 R5 R7 R9 through the vector table
        for (int k = 0; k < NV; k++) begin
            case (k)
                1:       run_vec(VEC[k], k, "R4 fan-out");
                2:       run_vec(VEC[k], k, "R5 stall on missing source");
                3:       run_vec(VEC[k], k, "R5 commit after stall");
                4:       run_vec(VEC[k], k, "R7 idle step passed, R3 swap");
                default: run_vec(VEC[k], k, "R3 routing");
            endcase
        end

        // R8: load while running is ignored; slot 5 must still route N to E
        load(4'd5, mk(3'd7, 3'd7, 3'd1, 3'd7, 3'd7, 4'd5));
        run_vec({5'h01, 5'h04, 3'd7, 3'd7, 3'd0, 3'd7, 3'd7}, 20, "R8 load ignored out of reset");

        // R6: hold, then drain and load on the same edge
        @(negedge clk);
        out_ready[2] = 1'b0;
        push1(0, 32'h1111_AAAA);
        @(negedge clk);
        chk(out_valid[2] && out_data[2] == 32'h1111_AAAA, "R3 word routed", out_data[2], 32'h1111_AAAA);
        push1(0, 32'h2222_BBBB);
        @(negedge clk);
        chk(out_valid[2] && out_data[2] == 32'h1111_AAAA, "R6 held while not ready", out_data[2], 32'h1111_AAAA);
        out_ready[2] = 1'b1;
        @(negedge clk);
        chk(out_valid[2] && out_data[2] == 32'h2222_BBBB, "R6 drain and load same edge", out_data[2], 32'h2222_BBBB);
        @(negedge clk);
        chk(out_valid == '0, "R5 stall on empty source", 32'(out_valid), 0);

        // second program: fan-out loop with one blocked destination
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == '0 && in_ready == '1, "R1 reset mid-run", 32'({out_valid, in_ready}), 32'h1F);
        load(4'd0, mk(3'd4, 3'd4, 3'd7, 3'd7, 3'd7, 4'd0));
        @(negedge clk);
        rst_n = 1'b1;
        out_ready = 5'b11101;
        push1(4, 32'hC0C0_0001);
        @(negedge clk);
        chk(out_valid[0] && out_valid[1] && out_data[0] == 32'hC0C0_0001 && out_data[1] == 32'hC0C0_0001,
            "R4 same word to both", out_data[1], 32'hC0C0_0001);
        @(negedge clk);
        chk(!out_valid[0] && out_valid[1] && out_data[1] == 32'hC0C0_0001, "R6 blocked output held",
            32'(out_valid), 32'h2);
        in_valid[4] = 1'b1; in_data[4] = 32'hC0C0_0002;
        @(negedge clk);
        in_data[4] = 32'hC0C0_0003;
        @(negedge clk);
        in_data[4] = 32'hC0C0_0004;
        @(negedge clk);
        chk(in_ready[4] == 1'b0, "R2 fifo full", 32'(in_ready[4]), 0);
        chk(out_valid[0] == 1'b0, "R5 free output untouched while blocked", 32'(out_valid[0]), 0);
        in_valid[4] = 1'b0;
        out_ready = '1;
        @(negedge clk);
        chk(out_valid[0] && out_data[0] == 32'hC0C0_0002 && out_data[1] == 32'hC0C0_0002,
            "R5 commit once unblocked", out_data[0], 32'hC0C0_0002);
        @(negedge clk);
        chk(out_valid[1] && out_data[1] == 32'hC0C0_0003, "R2 second queued word", out_data[1], 32'hC0C0_0003);
        @(negedge clk);
        chk(out_valid == '0, "R2 word offered while full dropped", 32'(out_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule